// File: doc/BRIEF.md
# Timestamp-Window Event Fragment Merger

The block joins event fragments arriving on several readout streams into a single stream of complete detector events. Each input stream carries fragments. A fragment is one header word, which holds a timestamp and a hit count, followed by that many hit words. The block reduces each timestamp to a window index by dropping its low bits. It fuses the fragments of all streams that share the lowest pending window into one output event, so the merge needs no software step and adds no software latency.

An output event is one header word, which holds the window index and a mask of the contributing streams. The hit words of the contributing streams follow, concatenated in ascending stream order. The block opens an event when every stream presents a fragment header. It also opens one when some streams have been waiting for a fixed timeout while the others stay silent. Streams whose head belongs to a later window stay untouched and wait for a later event. Backpressure on the output stalls every input, and no word is lost or reordered. The reset `rst_n` is asynchronous and active low, and it is expected to be deasserted synchronously to `clk`.

Top module: `ts_window_merger`

## Requirements
- R1: During reset and after reset with no input activity, `out_valid` is 0 and `in_ready` is all zeros.
- R2: A fragment header word carries the timestamp in bits [TS_W-1:0] and the hit count in bits [DATA_W-1 -: CNT_W], and it is marked by `in_sof`. The window index of a fragment is timestamp >> WIN_SHIFT, so fragments with different timestamps in the same window merge into one event.
- R3: An event opens as soon as every source holds a valid fragment header. If only some sources hold one, the event opens after TIMEOUT_CYC cycles of waiting, with those sources only.
- R4: Each event takes the lowest window index among the waiting fragment headers. Sources whose head shows a later window are not consumed and appear in later events, in increasing window order.
- R5: The first word of an event has `out_sof`=1. It carries the window index in bits [WIN_W-1:0] and the contributor mask in bits [DATA_W-1 -: NUM_SRC], where bit i stands for source i. All other bits are 0.
- R6: After the header come the hit words of the contributing sources, in ascending source order, each source's words in arrival order. Fragment header words are consumed and not forwarded.
- R7: `out_eof` is 1 on the last word of each event only. An event whose contributors carry zero hits consists of the header alone, with `out_sof` and `out_eof` both 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output word and its markers are held and no hit word is taken from any input. No word is lost or duplicated.
- R9: A source with no fragment in the event's window has mask bit 0 and adds no words to that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_SRC | Per-source word valid |
| in_sof | input | NUM_SRC | Per-source marker: word is a fragment header |
| in_data | input | NUM_SRC*DATA_W | Per-source word, source i in bits [i*DATA_W +: DATA_W] |
| in_ready | output | NUM_SRC | Per-source word accepted |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted by the sink |
| out_sof | output | 1 | Output word is an event header |
| out_eof | output | 1 | Output word is the last of its event |
| out_data | output | DATA_W | Output word |

## Verification
On every cycle, the assertions check the output stream's protocol. A held word stays stable under backpressure. A hit word is consumed only when it is forwarded in the same cycle. At most one hit word is taken per cycle. Fragment headers are consumed silently, and the start and end markers pair up properly. The bench scenarios are needed to show what the words contain: the window grouping of timestamps, the choice of the lowest window, the contributor masks, the ascending source concatenation, the timeout latency and the exclusion of absent sources.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_HEADER  = 2'd1,
    ST_DRAIN   = 2'd2
  } merge_state_e;
endpackage

// File: rtl/merge_window_pick.sv
module merge_window_pick #(
  parameter int NUM_SRC = 4,
  parameter int WIN_W   = 12
) (
  input  logic [NUM_SRC-1:0]            head_valid,
  input  logic [NUM_SRC-1:0][WIN_W-1:0] head_win,
  output logic [WIN_W-1:0]              min_win,
  output logic [NUM_SRC-1:0]            win_mask,
  output logic                          any_valid,
  output logic                          all_valid
);
  logic seen;

  always_comb begin
    seen    = 1'b0;
    min_win = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (head_valid[i] && (!seen || head_win[i] < min_win)) begin
        min_win = head_win[i];
        seen    = 1'b1;
      end
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      win_mask[i] = head_valid[i] && (head_win[i] == min_win);
    end
    any_valid = |head_valid;
    all_valid = &head_valid;
  end
endmodule

// File: rtl/merge_timeout.sv
module merge_timeout #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMO_W-1:0] LAST = TMO_W'(TIMEOUT_CYC - 1);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/merge_lowest_active.sv
module merge_lowest_active #(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0][CNT_W-1:0] counts,
  output logic [IDX_W-1:0]              idx,
  output logic                          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (counts[i] != '0) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ts_window_merger.sv
module ts_window_merger
  import merge_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int DATA_W      = 32,
  parameter int TS_W        = 16,
  parameter int WIN_SHIFT   = 4,
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          in_valid,
  input  logic [NUM_SRC-1:0]          in_sof,
  input  logic [NUM_SRC*DATA_W-1:0]   in_data,
  output logic [NUM_SRC-1:0]          in_ready,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_sof,
  output logic                        out_eof,
  output logic [DATA_W-1:0]           out_data
);
  localparam int WIN_W = TS_W - WIN_SHIFT;
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int TOT_W = CNT_W + $clog2(NUM_SRC + 1);

  merge_state_e                   state_q, state_d;
  logic [WIN_W-1:0]               win_q, win_d;
  logic [NUM_SRC-1:0]             mask_q, mask_d;
  logic [NUM_SRC-1:0][CNT_W-1:0]  cnt_q, cnt_d;
  logic [TOT_W-1:0]               total_q, total_d;
  logic                           reg_en;

  logic [DATA_W-1:0]              src_word [NUM_SRC];
  logic [NUM_SRC-1:0][WIN_W-1:0]  head_win;
  logic [NUM_SRC-1:0][CNT_W-1:0]  head_cnt;

  logic [WIN_W-1:0]   pick_win;
  logic [NUM_SRC-1:0] pick_mask;
  logic               any_valid, all_valid;
  logic               tmo_run, tmo_exp;
  logic [IDX_W-1:0]   cur_idx;
  logic               cur_found;
  logic               open_evt, hdr_done, xfer;
  logic [DATA_W-1:0]  hdr_word;

  // Per-source field views of the head words
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_word[g] = in_data[g*DATA_W +: DATA_W];
    assign head_win[g] = src_word[g][TS_W-1:WIN_SHIFT];
    assign head_cnt[g] = src_word[g][DATA_W-1 -: CNT_W];
  end

  merge_window_pick #(.NUM_SRC(NUM_SRC), .WIN_W(WIN_W)) u_pick (
    .head_valid (in_valid),
    .head_win   (head_win),
    .min_win    (pick_win),
    .win_mask   (pick_mask),
    .any_valid  (any_valid),
    .all_valid  (all_valid)
  );

  assign tmo_run = (state_q == ST_COLLECT) && any_valid && !all_valid;

  merge_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmo_run),
    .expired (tmo_exp)
  );

  merge_lowest_active #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_low (
    .counts (cnt_q),
    .idx    (cur_idx),
    .found  (cur_found)
  );

  assign open_evt = (state_q == ST_COLLECT) && any_valid && (all_valid || tmo_exp);
  assign hdr_done = (state_q == ST_HEADER) && out_ready;
  assign xfer     = (state_q == ST_DRAIN) && cur_found && in_valid[cur_idx] && out_ready;
  assign reg_en   = open_evt || hdr_done || xfer;

  // Next-state process
  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    mask_d  = mask_q;
    cnt_d   = cnt_q;
    total_d = total_q;
    case (state_q)
      ST_COLLECT: begin
        if (open_evt) begin
          win_d   = pick_win;
          mask_d  = pick_mask;
          total_d = '0;
          for (int i = 0; i < NUM_SRC; i++) begin
            cnt_d[i] = pick_mask[i] ? head_cnt[i] : '0;
            total_d  = total_d + {{(TOT_W-CNT_W){1'b0}}, cnt_d[i]};
          end
          state_d = ST_HEADER;
        end
      end
      ST_HEADER: begin
        if (out_ready) begin
          state_d = (total_q == '0) ? ST_COLLECT : ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (xfer) begin
          cnt_d[cur_idx] = cnt_q[cur_idx] - 1'b1;
          total_d        = total_q - 1'b1;
          if (total_q == TOT_W'(1)) begin
            state_d = ST_COLLECT;
          end
        end
      end
      default: state_d = ST_COLLECT;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      win_q   <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      total_q <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      win_q   <= win_d;
      mask_q  <= mask_d;
      cnt_q   <= cnt_d;
      total_q <= total_d;
    end
  end

  // Output and ready generation
  always_comb begin
    hdr_word                       = '0;
    hdr_word[WIN_W-1:0]            = win_q;
    hdr_word[DATA_W-1 -: NUM_SRC]  = mask_q;
  end

  always_comb begin
    out_valid = 1'b0;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    out_data  = '0;
    case (state_q)
      ST_HEADER: begin
        out_valid = 1'b1;
        out_sof   = 1'b1;
        out_eof   = (total_q == '0);
        out_data  = hdr_word;
      end
      ST_DRAIN: begin
        out_valid = cur_found && in_valid[cur_idx];
        out_eof   = (total_q == TOT_W'(1));
        out_data  = src_word[cur_idx];
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rdy
    assign in_ready[g] = (open_evt && pick_mask[g]) ||
                         ((state_q == ST_DRAIN) && cur_found &&
                          (cur_idx == IDX_W'(g)) && out_ready);
  end
endmodule

// File: rtl/merge_checker.sv
module merge_checker #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] in_valid,
  input logic [NUM_SRC-1:0] in_sof,
  input logic [NUM_SRC-1:0] in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_sof,
  input logic               out_eof,
  input logic [DATA_W-1:0]  out_data
);
  logic in_event_q;
  logic [NUM_SRC-1:0] hit_pop, hdr_pop;

  assign hit_pop = in_valid & in_ready & ~in_sof;
  assign hdr_pop = in_valid & in_ready & in_sof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_event_q <= 1'b0;
    end else if (out_valid && out_ready) begin
      in_event_q <= !out_eof;
    end
  end

  AST_HDR_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_data[DATA_W-1 -: NUM_SRC] != '0); // R5

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)); // R8

  AST_HIT_ONLY_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pop != '0 |-> out_valid && out_ready); // R8

  AST_ONE_HIT_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_pop)); // R6

  AST_FRAG_HDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_pop != '0 |-> !out_valid); // R6

  AST_SOF_STARTS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !in_event_q); // R7

  AST_BODY_INSIDE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sof |-> in_event_q); // R7
endmodule

bind ts_window_merger merge_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .out_data  (out_data)
);

// File: tb/ts_window_merger_tb.sv
module ts_window_merger_tb;
  localparam int N   = 4;
  localparam int DW  = 32;
  localparam int TSW = 16;
  localparam int SH  = 4;
  localparam int CW  = 8;
  localparam int TO  = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    in_valid;
  logic [N-1:0]    in_sof;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    in_ready;
  logic            out_valid, out_ready, out_sof, out_eof;
  logic [DW-1:0]   out_data;

  always #5 clk = ~clk;

  ts_window_merger #(.NUM_SRC(N), .DATA_W(DW), .TS_W(TSW), .WIN_SHIFT(SH),
                     .CNT_W(CW), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data)
  );

  logic [DW:0]   src_q [N][$];
  logic [DW-1:0] hits  [N][$];
  logic [DW+1:0] exp_q [$];
  logic [N-1:0]  rdy_seen;
  int            checks = 0;
  int            fails  = 0;
  string         req    = "R1";
  bit            hold_low = 1'b0;
  bit            running  = 1'b0;
  logic [7:0]    lfsr = 8'h5A;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Source driver: one process, all sources, changes only at negedge
  initial begin
    in_valid = '0; in_sof = '0; in_data = '0; rdy_seen = '0;
    forever begin
      @(negedge clk);
      for (int s = 0; s < N; s++) begin
        logic [DW:0] w;
        if (in_valid[s] && rdy_seen[s]) in_valid[s] = 1'b0;
        if (!in_valid[s] && running && src_q[s].size() > 0) begin
          w = src_q[s].pop_front();
          in_valid[s] = 1'b1;
          in_sof[s]   = w[DW];
          in_data[s*DW +: DW] = w[DW-1:0];
        end
      end
      #2;
      rdy_seen = in_ready;
    end
  end

  // Sink and scoreboard monitor
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = !hold_low && (lfsr[1:0] != 2'b00);
      #2;
      if (rst_n && out_valid && out_ready) begin
        logic [DW+1:0] e;
        if (exp_q.size() == 0) begin
          chk(1'b0, req, "unexpected output word", {out_sof, out_eof, out_data}, 0);
        end else begin
          e = exp_q.pop_front();
          chk({out_sof, out_eof, out_data} == e, req, "output word {sof,eof,data}",
              {out_sof, out_eof, out_data}, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    summary();
  end

  // Fragment: header {count, zeros, ts} with sof, then hit words
  task automatic add_frag(input int s, input logic [TSW-1:0] ts, input int n);
    logic [DW-1:0] h;
    h = '0;
    h[TSW-1:0] = ts;
    h[DW-1 -: CW] = CW'(n);
    src_q[s].push_back({1'b1, h});
    for (int k = 0; k < n; k++) begin
      logic [DW-1:0] w;
      w = {4'hA, 4'(s), ts, 8'(k)};
      src_q[s].push_back({1'b0, w});
      hits[s].push_back(w);
    end
  endtask

  task automatic expect_event(input logic [TSW-SH-1:0] win, input logic [N-1:0] mask);
    int total, left;
    logic [DW-1:0] h;
    total = 0;
    for (int s = 0; s < N; s++) if (mask[s]) total += hits[s].size();
    h = '0;
    h[TSW-SH-1:0] = win;
    h[DW-1 -: N] = mask;
    exp_q.push_back({1'b1, total == 0, h});
    left = total;
    for (int s = 0; s < N; s++) begin
      if (mask[s]) begin
        foreach (hits[s][k]) begin
          left--;
          exp_q.push_back({1'b0, left == 0, hits[s][k]});
        end
        hits[s].delete();
      end
    end
  endtask

  task automatic wait_idle();
    bit busy;
    busy = 1'b1;
    while (busy) begin
      @(negedge clk); #3;
      busy = (exp_q.size() != 0) || (in_valid != '0);
      for (int s = 0; s < N; s++) if (src_q[s].size() != 0) busy = 1'b1;
    end
    repeat (3) @(negedge clk);
    #3;
    chk(!out_valid && in_ready == '0, req, "idle after scenario {out_valid,in_ready}",
        {out_valid, in_ready}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk(!out_valid && in_ready == '0, "R1", "in reset {out_valid,in_ready}", {out_valid, in_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    chk(!out_valid && in_ready == '0, "R1", "after reset {out_valid,in_ready}", {out_valid, in_ready}, 0);
    running = 1'b1;

    // R2 R5 R6: four timestamps, one window (3), differing low bits
    req = "R2";
    add_frag(0, 16'd49, 2); add_frag(1, 16'd55, 3);
    add_frag(2, 16'd48, 1); add_frag(3, 16'd63, 4);
    expect_event(12'd3, 4'hF);
    wait_idle();

    // R4 R9 R3: sources 0,2 in window 5; sources 1,3 in window 6 via timeout
    req = "R4";
    add_frag(0, 16'd80, 2); add_frag(2, 16'd85, 1);
    add_frag(1, 16'd96, 3); add_frag(3, 16'd100, 2);
    expect_event(12'd5, 4'b0101);
    expect_event(12'd6, 4'b1010);
    wait_idle();

    // R7 R3: single empty fragment, header-only event after timeout
    req = "R7";
    begin
      int lat;
      add_frag(2, 16'd130, 0);
      expect_event(12'd8, 4'b0100);
      while (!in_valid[2]) begin @(negedge clk); #3; end
      lat = 0;
      while (!out_valid && lat < 4 * TO) begin @(negedge clk); #3; lat++; end
      chk(lat >= TO - 1 && lat <= TO + 1, "R3", "timeout latency", lat, TO);
    end
    wait_idle();

    // R4: windows in reverse source order, drained lowest window first
    req = "R4";
    add_frag(3, 16'd320, 1); add_frag(2, 16'd337, 2);
    add_frag(1, 16'd352, 0); add_frag(0, 16'd370, 3);
    expect_event(12'd20, 4'b1000);
    expect_event(12'd21, 4'b0100);
    expect_event(12'd22, 4'b0010);
    expect_event(12'd23, 4'b0001);
    wait_idle();

    // R8: long stall holds the header and takes no hit word
    req = "R8";
    hold_low = 1'b1;
    add_frag(0, 16'd480, 1); add_frag(1, 16'd481, 1);
    add_frag(2, 16'd482, 1); add_frag(3, 16'd483, 1);
    expect_event(12'd30, 4'hF);
    begin
      logic [DW+1:0] first;
      int guard;
      guard = 0;
      while (!out_valid && guard < 4 * TO) begin @(negedge clk); #3; guard++; end
      first = {out_sof, out_eof, out_data};
      for (int c = 0; c < 12; c++) begin
        @(negedge clk); #3;
        chk(out_valid && {out_sof, out_eof, out_data} == first && (in_ready == '0),
            "R8", "held word under stall", {out_valid, in_ready, out_sof, out_eof, out_data},
            {1'b1, 4'b0, first});
      end
    end
    hold_low = 1'b0;
    wait_idle();

    // R9: source 2 silent; it is left out of the window-40 event
    req = "R9";
    add_frag(0, 16'd640, 2); add_frag(1, 16'd650, 0); add_frag(3, 16'd655, 2);
    expect_event(12'd40, 4'b1011);
    wait_idle();

    // R6: uneven counts, back-to-back events in the same source order
    req = "R6";
    add_frag(0, 16'd800, 0); add_frag(1, 16'd801, 5);
    add_frag(2, 16'd802, 0); add_frag(3, 16'd803, 1);
    expect_event(12'd50, 4'hF);
    add_frag(0, 16'd816, 3); add_frag(1, 16'd817, 0);
    add_frag(2, 16'd818, 2); add_frag(3, 16'd819, 0);
    expect_event(12'd51, 4'hF);
    wait_idle();

    summary();
  end
endmodule